// File: doc/BRIEF.md
# Dual 8-Bit Timer with Pulse Generation

This block holds two 8-bit up counters that share one free-running prescaler and one output flip-flop. A 2-bit mode input sets how the pair works. In one mode the counters are two separate interval timers. In another they form a single cascaded 16-bit timer. The last two modes use counter 0 alone, either as a two-edge programmable pulse generator or as a pulse-width modulator whose period is a power of two. Each channel picks its count rate from a prescaler tap. Software holds the compare values on plain inputs and drives a one-cycle command strobe for the flip-flop.

Every match or period event gives a one-cycle interrupt pulse on one of two outputs. The flip-flop level is the waveform output. A run input starts the prescaler and both counters together. When run is low they are held at zero, so each start begins a fresh count. Mode, taps and compare values are meant to change only while run is low.

Top module: `dual_timer8`

## Requirements
- R1: After reset, `irq0`, `irq1` and `ff_out` are all low.
- R2: The prescaler runs only while `run` is high. A channel's tap select picks a count tick every cycle (00), every 16 cycles (01), every 256 cycles (10) or every 512 cycles (11). The first tick comes D cycles after `run` rises, where D is that divisor.
- R3: While `run` is low the prescaler and both counters are held at zero and no interrupt is raised. Raising `run` again repeats exactly the timing of a fresh start.
- R4: In mode 00, each counter steps once per tick of its own channel. On a tick where the counter equals its compare value, it returns to zero and its interrupt (`irq0` for channel 0, `irq1` for channel 1) is high for the cycle after that clock edge. This gives a period of (compare+1)·D cycles.
- R5: In mode 01, the counters form one 16-bit count {counter1, counter0} stepped by channel 0's tick. When both halves equal {cmp1, cmp0}, the count clears and `irq1` pulses. `irq0` stays low.
- R6: In mode 10, counter 0 steps on channel 0's tick. When it equals `cmp0`, `irq0` pulses and counting goes on. When it equals `cmp1`, it clears and `irq1` pulses. The period is (cmp1+1)·D cycles.
- R7: In mode 11, counter 0 wraps with a period P set by `pwm_cyc`: 01 gives 64, 10 gives 128, and 11 or 00 gives 256. Each wrap pulses `irq1`.
- R8: In mode 11, the output is set at each wrap unless `cmp0` is 0. It is cleared, with an `irq0` pulse and no counter clear, on the tick where the counter becomes `cmp0`. So it is high for cmp0·D of every P·D cycles. If `cmp0` is P or more, it stays high. If `cmp0` is 0, it stays low.
- R9: With `inv_en` high, timer events invert the output. In mode 00, `inv_sel` picks channel 0 (0) or channel 1 (1). In mode 01, the 16-bit match inverts it. In mode 10, both matches invert it. With `inv_en` low, the output is not changed by these modes.
- R10: A cycle with `ff_wr` high applies `ff_cmd` to the output at the next edge: 00 inverts, 01 sets, 10 clears, and 11 leaves it unchanged. Any command other than 11 takes priority over a timer event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Start (1) or stop and clear (0) prescaler and counters |
| mode | input | 2 | 00 two 8-bit timers, 01 16-bit, 10 pulse generator, 11 PWM |
| pwm_cyc | input | 2 | PWM period select |
| clk_sel0 | input | 2 | Prescaler tap for channel 0 |
| clk_sel1 | input | 2 | Prescaler tap for channel 1 |
| cmp0 | input | CNT_W | Compare value, channel 0 |
| cmp1 | input | CNT_W | Compare value, channel 1 |
| inv_en | input | 1 | Allow timer events to invert the output |
| inv_sel | input | 1 | In mode 00: 0 channel 0, 1 channel 1 inverts |
| ff_wr | input | 1 | Command strobe for the output flip-flop |
| ff_cmd | input | 2 | Flip-flop command |
| irq0 | output | 1 | Channel 0 match pulse |
| irq1 | output | 1 | Channel 1, 16-bit match or period pulse |
| ff_out | output | 1 | Flip-flop level |

## Verification
The bench builds the block with its default widths: 8-bit counters, a 9-bit prescaler and a tap spacing of 4. This gives divisors of 1, 16, 256 and 512 and PWM periods of 64, 128 and 256, all within a short run. A 16-bit compare value of 300 forces a carry from the low byte into the high byte before the match. The slowest taps are used with small compare values, so both channels' events fall on the same cycle in mode 00.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
   typedef enum logic [1:0] {
      MODE_T8  = 2'b00,
      MODE_T16 = 2'b01,
      MODE_PPG = 2'b10,
      MODE_PWM = 2'b11
   } tmode_e;

   typedef enum logic [1:0] {
      FF_INV  = 2'b00,
      FF_SET  = 2'b01,
      FF_CLR  = 2'b10,
      FF_KEEP = 2'b11
   } ffcmd_e;
endpackage

// File: rtl/dtmr_prescaler.sv
module dtmr_prescaler #(
   parameter int PSC_W    = 9,
   parameter int TAP_STEP = 4,
   parameter int NCH      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [2*NCH-1:0] sel,
   output logic [NCH-1:0]   tick
);
   localparam int HI_TAP = 2 * TAP_STEP;

   if (HI_TAP >= PSC_W) begin : g_bad_taps
      $error("dtmr_prescaler: taps exceed prescaler width");
   end

   logic [PSC_W-1:0] psc;
   logic [3:0]       tap_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   psc <= '0;
      else if (run) psc <= psc + 1'b1;
      else          psc <= '0;
   end

   // tap k fires once every 2^(k*TAP_STEP) cycles, the last tap on full wrap
   assign tap_hit[0] = 1'b1;
   assign tap_hit[1] = &psc[TAP_STEP-1:0];
   assign tap_hit[2] = &psc[HI_TAP-1:0];
   assign tap_hit[3] = &psc;

   for (genvar c = 0; c < NCH; c++) begin : g_tick
      assign tick[c] = run & tap_hit[sel[2*c +: 2]];
   end

   // R3: a fresh start always finds the prescaler at zero
   p_restart_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> (psc == '0));
endmodule

// File: rtl/dtmr_core.sv
module dtmr_core
   import dtmr_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  tmode_e           mode,
   input  logic [1:0]       pwm_cyc,
   input  logic             tick0,
   input  logic             tick1,
   input  logic [CNT_W-1:0] cmp0,
   input  logic [CNT_W-1:0] cmp1,
   output logic             ev0,
   output logic             ev1,
   output logic             pwm_set,
   output logic             pwm_clr,
   output logic             irq0,
   output logic             irq1
);
   localparam int WIDE_W = 2 * CNT_W;

   if (CNT_W < 4) begin : g_bad_width
      $error("dtmr_core: counter width too small for PWM periods");
   end

   logic [CNT_W-1:0]  cnt0, cnt1, cnt0_n, cnt1_n;
   logic [CNT_W-1:0]  mask, pwm_nx;
   logic [WIDE_W-1:0] wide_nx;
   logic              lo_eq, hi_eq;

   always_comb begin
      case (pwm_cyc)
         2'b01:   mask = {CNT_W{1'b1}} >> 2;
         2'b10:   mask = {CNT_W{1'b1}} >> 1;
         default: mask = {CNT_W{1'b1}};
      endcase
   end

   assign lo_eq   = (cnt0 == cmp0);
   assign hi_eq   = (cnt1 == cmp1);
   assign pwm_nx  = (cnt0 + 1'b1) & mask;
   assign wide_nx = {cnt1, cnt0} + 1'b1;

   always_comb begin
      cnt0_n  = cnt0;
      cnt1_n  = cnt1;
      ev0     = 1'b0;
      ev1     = 1'b0;
      pwm_set = 1'b0;
      pwm_clr = 1'b0;
      case (mode)
         MODE_T8: begin
            if (tick0) begin
               if (lo_eq) begin cnt0_n = '0; ev0 = 1'b1; end
               else             cnt0_n = cnt0 + 1'b1;
            end
            if (tick1) begin
               if (hi_eq) begin cnt1_n = '0; ev1 = 1'b1; end
               else             cnt1_n = cnt1 + 1'b1;
            end
         end
         MODE_T16: begin
            // the low-half match only counts when the high half also agrees
            if (tick0) begin
               if (lo_eq && hi_eq) begin
                  cnt0_n = '0;
                  cnt1_n = '0;
                  ev1    = 1'b1;
               end else begin
                  {cnt1_n, cnt0_n} = wide_nx;
               end
            end
         end
         MODE_PPG: begin
            cnt1_n = '0;
            if (tick0) begin
               if (cnt0 == cmp1) begin cnt0_n = '0; ev1 = 1'b1; end
               else begin
                  cnt0_n = cnt0 + 1'b1;
                  ev0    = lo_eq;
               end
            end
         end
         default: begin
            cnt1_n = '0;
            if (tick0) begin
               cnt0_n  = pwm_nx;
               ev1     = (pwm_nx == '0);
               ev0     = (pwm_nx == cmp0);
               pwm_set = ev1 && (cmp0 != '0);
               pwm_clr = ev0;
            end
         end
      endcase
      if (!run) begin
         cnt0_n = '0;
         cnt1_n = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt0 <= '0;
         cnt1 <= '0;
         irq0 <= 1'b0;
         irq1 <= 1'b0;
      end else begin
         cnt0 <= cnt0_n;
         cnt1 <= cnt1_n;
         irq0 <= ev0;
         irq1 <= ev1;
      end
   end

   // R4: a channel-0 pulse in timer mode leaves the counter at zero
   p_t8_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_T8 && $past(mode == MODE_T8) && irq0) |-> (cnt0 == '0));

   // R5: a full 16-bit match leaves both halves at zero
   p_t16_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_T16 && $past(mode == MODE_T16) && irq1) |-> (cnt0 == '0 && cnt1 == '0));

   // R5: no channel-0 pulse while cascaded
   p_t16_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_T16 && $past(mode == MODE_T16)) |-> !irq0);

   // R7: the PWM count never leaves the selected period
   p_pwm_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_PWM && $past(mode == MODE_PWM) && $stable(pwm_cyc)) |-> ((cnt0 & ~mask) == '0));

   // R3: stopped counters raise nothing
   p_stop_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!irq0 && !irq1));
endmodule

// File: rtl/dtmr_outff.sv
module dtmr_outff
   import dtmr_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  tmode_e mode,
   input  logic   inv_en,
   input  logic   inv_sel,
   input  logic   ev0,
   input  logic   ev1,
   input  logic   pwm_set,
   input  logic   pwm_clr,
   input  logic   ff_wr,
   input  ffcmd_e ff_cmd,
   output logic   ff_out
);
   logic tog;

   always_comb begin
      case (mode)
         MODE_T8:  tog = inv_en & (inv_sel ? ev1 : ev0);
         MODE_T16: tog = inv_en & ev1;
         MODE_PPG: tog = inv_en & (ev0 | ev1);
         default:  tog = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ff_out <= 1'b0;
      end else if (ff_wr && ff_cmd != FF_KEEP) begin
         case (ff_cmd)
            FF_INV:  ff_out <= ~ff_out;
            FF_SET:  ff_out <= 1'b1;
            default: ff_out <= 1'b0;
         endcase
      end else if (pwm_clr) begin
         ff_out <= 1'b0;
      end else if (pwm_set) begin
         ff_out <= 1'b1;
      end else if (tog) begin
         ff_out <= ~ff_out;
      end
   end

   // R10: set and clear commands land on the next edge
   p_cmd_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ff_wr && ff_cmd == FF_SET) |-> ff_out);
   p_cmd_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ff_wr && ff_cmd == FF_CLR) |-> !ff_out);
   // R10: invert command flips the level
   p_cmd_inv_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ff_wr && ff_cmd == FF_INV) |-> (ff_out != $past(ff_out)));
endmodule

// File: rtl/dual_timer8.sv
module dual_timer8
   import dtmr_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int PSC_W    = 9,
   parameter int TAP_STEP = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [1:0]       mode,
   input  logic [1:0]       pwm_cyc,
   input  logic [1:0]       clk_sel0,
   input  logic [1:0]       clk_sel1,
   input  logic [CNT_W-1:0] cmp0,
   input  logic [CNT_W-1:0] cmp1,
   input  logic             inv_en,
   input  logic             inv_sel,
   input  logic             ff_wr,
   input  logic [1:0]       ff_cmd,
   output logic             irq0,
   output logic             irq1,
   output logic             ff_out
);
   localparam int NCH = 2;

   tmode_e         mode_e;
   logic [NCH-1:0] tick;
   logic           ev0, ev1, pwm_set, pwm_clr;

   assign mode_e = tmode_e'(mode);

   dtmr_prescaler #(.PSC_W(PSC_W), .TAP_STEP(TAP_STEP), .NCH(NCH)) u_psc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .sel   ({clk_sel1, clk_sel0}),
      .tick  (tick)
   );

   dtmr_core #(.CNT_W(CNT_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .mode    (mode_e),
      .pwm_cyc (pwm_cyc),
      .tick0   (tick[0]),
      .tick1   (tick[1]),
      .cmp0    (cmp0),
      .cmp1    (cmp1),
      .ev0     (ev0),
      .ev1     (ev1),
      .pwm_set (pwm_set),
      .pwm_clr (pwm_clr),
      .irq0    (irq0),
      .irq1    (irq1)
   );

   dtmr_outff u_ff (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode_e),
      .inv_en  (inv_en),
      .inv_sel (inv_sel),
      .ev0     (ev0),
      .ev1     (ev1),
      .pwm_set (pwm_set),
      .pwm_clr (pwm_clr),
      .ff_wr   (ff_wr),
      .ff_cmd  (ffcmd_e'(ff_cmd)),
      .ff_out  (ff_out)
   );

   // R8: a PWM wrap with a nonzero duty drives the output high
   p_pwm_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b11 && $past(mode == 2'b11) && irq1 && !$past(ff_wr) && $past(cmp0) != '0)
      |-> ff_out);
endmodule

// File: tb/test_dual_timer8.sv
module test_dual_timer8;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run = 1'b0;
   logic [1:0] mode = 2'b00;
   logic [1:0] pwm_cyc = 2'b00;
   logic [1:0] clk_sel0 = 2'b00;
   logic [1:0] clk_sel1 = 2'b00;
   logic [7:0] cmp0 = 8'd0;
   logic [7:0] cmp1 = 8'd0;
   logic       inv_en = 1'b0;
   logic       inv_sel = 1'b0;
   logic       ff_wr = 1'b0;
   logic [1:0] ff_cmd = 2'b11;
   logic       irq0, irq1, ff_out;

   typedef struct {
      int edge_no;
      bit b0;
      bit b1;
   } exp_t;

   exp_t  exp_q[$];
   int    total = 0;
   int    bad = 0;
   int    ncyc = 0;
   int    win_lo = 1 << 30;
   int    win_hi = 0;
   int    mon_hi = 0;
   string cur_req = "R1";

   always #4 clk = ~clk;

   dual_timer8 i_dual_timer8 (
      .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .pwm_cyc(pwm_cyc),
      .clk_sel0(clk_sel0), .clk_sel1(clk_sel1), .cmp0(cmp0), .cmp1(cmp1),
      .inv_en(inv_en), .inv_sel(inv_sel), .ff_wr(ff_wr), .ff_cmd(ff_cmd),
      .irq0(irq0), .irq1(irq1), .ff_out(ff_out)
   );

   task automatic check(input bit ok, input string req, input string msg);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s", req, msg);
      end
   endtask

   always @(posedge clk) ncyc <= ncyc + 1;

   // monitor: pops expected interrupt pulses and tallies output-high cycles
   always @(negedge clk) begin
      if (rst_n) begin
         if (ncyc >= win_lo && ncyc <= win_hi && ff_out) mon_hi = mon_hi + 1;
         if (irq0 || irq1) begin
            if (exp_q.size() == 0) begin
               check(1'b0, cur_req, $sformatf("unexpected pulse at cycle %0d bits irq1/irq0=%b%b, expected none",
                     ncyc, irq1, irq0));
            end else begin
               exp_t it;
               it = exp_q.pop_front();
               check(it.edge_no == ncyc && it.b0 == irq0 && it.b1 == irq1, cur_req,
                     $sformatf("pulse at cycle %0d bits %b%b, expected cycle %0d bits %b%b",
                               ncyc, irq1, irq0, it.edge_no, it.b1, it.b0));
            end
         end
      end
   end

   function automatic int divisor(input int s);
      return (s == 0) ? 1 : (s == 1) ? 16 : (s == 2) ? 256 : 512;
   endfunction

   task automatic ff_command(input int cmd);
      @(negedge clk);
      ff_wr  = 1'b1;
      ff_cmd = 2'(cmd);
      @(negedge clk);
      ff_wr  = 1'b0;
      ff_cmd = 2'b11;
   endtask

   // driver: compute expected pulses from the requirements, then run
   task automatic run_seg(input string req, input int md, input int cyc, input int s0, input int s1,
                          input int c0, input int c1, input bit ie, input bit is, input int nedge);
      int d0, d1, per, e0, m0, m1, m16, hi;
      bit ffm, t0, t1, b0, b1;
      exp_t it;
      ff_command(2);
      @(negedge clk);
      cur_req = req;
      mode = 2'(md); pwm_cyc = 2'(cyc); clk_sel0 = 2'(s0); clk_sel1 = 2'(s1);
      cmp0 = 8'(c0); cmp1 = 8'(c1); inv_en = ie; inv_sel = is;
      d0 = divisor(s0); d1 = divisor(s1);
      per = (cyc == 1) ? 64 : (cyc == 2) ? 128 : 256;
      e0 = ncyc;
      win_lo = e0 + 1; win_hi = e0 + nedge; mon_hi = 0;
      m0 = 0; m1 = 0; m16 = 0; hi = 0; ffm = 1'b0;
      for (int e = 1; e <= nedge; e++) begin
         t0 = (e % d0) == 0;
         t1 = (e % d1) == 0;
         b0 = 1'b0; b1 = 1'b0;
         case (md)
            0: begin
               if (t0) begin if (m0 == c0) begin m0 = 0; b0 = 1'b1; end else m0++; end
               if (t1) begin if (m1 == c1) begin m1 = 0; b1 = 1'b1; end else m1++; end
               if (ie && (is ? b1 : b0)) ffm = ~ffm;
            end
            1: begin
               if (t0) begin if (m16 == c1 * 256 + c0) begin m16 = 0; b1 = 1'b1; end else m16++; end
               if (ie && b1) ffm = ~ffm;
            end
            2: begin
               if (t0) begin
                  if (m0 == c1) begin m0 = 0; b1 = 1'b1; end
                  else begin b0 = (m0 == c0); m0++; end
               end
               if (ie && (b0 || b1)) ffm = ~ffm;
            end
            default: begin
               if (t0) begin
                  m0 = (m0 + 1) % per;
                  b1 = (m0 == 0);
                  b0 = (m0 == c0);
                  if (b1 && c0 != 0) ffm = 1'b1;
                  if (b0) ffm = 1'b0;
               end
            end
         endcase
         if (b0 || b1) begin
            it.edge_no = e0 + e; it.b0 = b0; it.b1 = b1;
            exp_q.push_back(it);
         end
         if (ffm) hi++;
      end
      run = 1'b1;
      repeat (nedge) @(negedge clk);
      run = 1'b0;
      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, req, $sformatf("missing pulses: %0d left, expected 0", exp_q.size()));
      exp_q.delete();
      check(mon_hi == hi, req, $sformatf("output-high cycles %0d, expected %0d", mon_hi, hi));
      check(ff_out == ffm, req, $sformatf("final output %b, expected %b", ff_out, ffm));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog", "run hung, actual timeout, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(irq0 == 1'b0, "R1", $sformatf("irq0 %b, expected 0", irq0));
      check(irq1 == 1'b0, "R1", $sformatf("irq1 %b, expected 0", irq1));
      check(ff_out == 1'b0, "R1", $sformatf("ff_out %b, expected 0", ff_out));
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R10: flip-flop commands
      ff_command(1);
      check(ff_out == 1'b1, "R10", $sformatf("after set %b, expected 1", ff_out));
      ff_command(0);
      check(ff_out == 1'b0, "R10", $sformatf("after invert %b, expected 0", ff_out));
      ff_command(0);
      check(ff_out == 1'b1, "R10", $sformatf("after invert %b, expected 1", ff_out));
      ff_command(3);
      check(ff_out == 1'b1, "R10", $sformatf("after no-action %b, expected 1", ff_out));
      ff_command(2);
      check(ff_out == 1'b0, "R10", $sformatf("after clear %b, expected 0", ff_out));

      // R4: two independent interval timers, channel 1 drives the output (R9)
      run_seg("R4", 0, 0, 0, 1, 5, 3, 1'b1, 1'b1, 400);
      // R3: the same setup again must restart from zero
      run_seg("R3", 0, 0, 0, 1, 5, 3, 1'b1, 1'b1, 400);
      // R9: channel 0 selected as inverting source
      run_seg("R9", 0, 0, 0, 0, 4, 6, 1'b1, 1'b0, 100);
      // R9: inversion disabled, output stays put
      run_seg("R9", 0, 0, 0, 0, 2, 2, 1'b0, 1'b0, 50);
      // R2: slow taps, coincident pulses at cycle 3072
      run_seg("R2", 0, 0, 2, 3, 2, 1, 1'b1, 1'b0, 3100);
      // R5: cascaded 16-bit, compare 300
      run_seg("R5", 1, 0, 0, 0, 44, 1, 1'b1, 1'b0, 700);
      // R6: programmable pulse, low match 3, period 10
      run_seg("R6", 2, 0, 0, 0, 3, 9, 1'b1, 1'b0, 95);
      // R7: PWM periods 64, 128 (with divide-by-16), 256 and reserved select
      run_seg("R7", 3, 1, 0, 0, 20, 0, 1'b0, 1'b0, 200);
      run_seg("R7", 3, 2, 1, 0, 100, 0, 1'b0, 1'b0, 4100);
      run_seg("R7", 3, 3, 0, 0, 200, 0, 1'b0, 1'b0, 600);
      run_seg("R7", 3, 0, 0, 0, 50, 0, 1'b0, 1'b0, 600);
      // R8: duty limits: compare beyond period and compare zero
      run_seg("R8", 3, 1, 0, 0, 100, 0, 1'b0, 1'b0, 200);
      run_seg("R8", 3, 1, 0, 0, 0, 0, 1'b0, 1'b0, 200);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule